// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital controller that sits in front of a successive-approximation converter. It picks one of four convert-start sources. It then runs the tracking, converting and idle phases with cycle budgets derived from a programmable SAR clock divider. Every count is in cycles of the block clock (FCLK). The analog sampler is reached only through a track-enable output, a busy (convert) window and a one-cycle take strobe. On the take strobe the block latches a 12-bit sample from the converter.

One of three tracking policies is applied. Tracking first: the input is tracked while idle and conversion starts at once. Tracking after start: a timed tracking window follows the start and the input is left disconnected afterwards. Both: a timed window follows the start and tracking resumes while idle. Results of 1, 4, 8 or 16 conversions are summed into one right-justified word. A sticky completion flag rises when busy falls on the last conversion of a series. In burst operation a single start runs the whole series back to back. When the enable input is clear in burst operation, the converter is powered down between bursts and waits a programmed power-up time after each start.

States: `ST_OFF` (powered down, starts ignored), `ST_IDLE` (waiting for a start), `ST_PWRUP` (burst power-up wait), `ST_TRACK` (timed tracking window), `ST_CONV` (converting, busy high). Transitions:
- OFF→IDLE when enable or burst is set.
- IDLE→CONV on a start under tracking-first.
- IDLE→PWRUP on a start in burst with enable clear.
- IDLE→TRACK on any other start.
- PWRUP→TRACK and TRACK→CONV when the phase budget runs out.
- CONV→IDLE at the end of a conversion, except within a burst.
- CONV→TRACK at the end of a conversion inside a burst that has conversions left.
- Any state→OFF when both enable and burst are clear.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, `busy`, `track_en`, `pwr_on`, `sample_take` and `done_flag` are 0 and `result` is 0.
- R2: `src_sel` picks the start source: 00 `sw_start` pulse, 01 `tmr3_ovf`, 10 rising edge of `ext_start`, 11 `tmr2_ovf`. The unselected sources have no effect. A level held high on `ext_start` starts only once.
- R3: `trk_mode` 01 (after-start) and 11 (both) each give a timed tracking window that begins the cycle after the start is sampled. During the window `track_en` is high and `busy` is low. The window lasts (N+1)·2^(K+1)+2 cycles, where N is `sar_div` and K is `trk_len`.
- R4: Each conversion keeps `busy` high for 13·(N+1)+2 cycles. The sample is latched from `sample_in` on the last busy cycle, which is flagged by `sample_take`.
- R5: `trk_mode` 10 (tracking-first) outside burst makes `busy` rise in the cycle after the start is sampled, with no tracking window.
- R6: While idle and enabled, `track_en` is 0 under mode 01 and 1 under modes 10 and 11. The reserved code 00 behaves as mode 11.
- R7: `rpt_sel` sets the series length: 00→1, 01→4, 10→8, 11→16. `done_flag` stays 0 until the last conversion of the series, and `result` then holds the unsigned sum of the latched samples.
- R8: `done_flag` rises in the same cycle that `busy` falls at the end of a series and then stays high. A `done_clr` pulse clears it.
- R9: A start that arrives while powering up, tracking or converting is ignored: it neither shortens nor lengthens the run and adds no conversion.
- R10: In burst (`burst_en`=1) one start runs the whole series. Each conversion is preceded by its own tracking window, and mode 10 is treated as mode 11.
- R11: In burst with `enable` clear, `pwr_on` rises after a start and stays high with `track_en` low for (P+1)·PWR_UNIT cycles before tracking, where P is `pwr_time`. Once the burst ends, `pwr_on` falls. In burst with `enable` set there is no wait and `pwr_on` stays high.
- R12: With `burst_en` and `enable` both clear, the block is powered down (`pwr_on`=0) and starts are ignored. Clearing `enable` in the middle of a series aborts it and discards the partial sum.
- R13: `result` changes only in the cycle after the last `sample_take` of a series.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FCLK, block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Converter enable; in burst, selects powered idle |
| burst_en | input | 1 | Burst operation select |
| src_sel | input | 2 | Start source select |
| trk_mode | input | 2 | Tracking policy code |
| trk_len | input | 2 | Tracking window length code K |
| sar_div | input | 5 | SAR clock divider N |
| pwr_time | input | 4 | Burst power-up time P |
| rpt_sel | input | 2 | Series length code |
| sw_start | input | 1 | Software start pulse |
| tmr3_ovf | input | 1 | Timer-3 overflow pulse |
| ext_start | input | 1 | External start pin |
| tmr2_ovf | input | 1 | Timer-2 overflow pulse |
| done_clr | input | 1 | Clears the completion flag |
| sample_in | input | 12 | Sample returned by the converter |
| pwr_on | output | 1 | Converter powered |
| track_en | output | 1 | Sampler connected to the input |
| busy | output | 1 | Conversion in progress |
| sample_take | output | 1 | Last conversion cycle, sample latched |
| done_flag | output | 1 | Series complete (sticky) |
| result | output | 16 | Summed, right-justified result |

## Verification
The bench measures every phase length cycle by cycle. A divider that is off by one, or a missing 2-cycle start/finish overhead, shows up as a wrong track or busy count. The series logic is checked by summing random samples taken in the exact last busy cycle; if the sample were taken one cycle early, or the accumulator not cleared between series, the sum would be wrong. Starts are fired during tracking and from unselected sources. Sources that are not properly masked, or a start that restarts the window, would give an extra conversion or a shortened window. A mid-series disable is followed by a fresh series, so a partial sum that is not discarded would show up in the next result. The bench also covers burst with and without the power-up wait, the reserved and tracking-first codes in burst, and the largest divider and window codes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DIV_W     = 5;   // SAR divider field width
    localparam int TK_W      = 2;   // tracking-length code width
    localparam int PWR_W     = 4;   // power-up field width
    localparam int CONV_SAR  = 13;  // SAR periods per conversion
    localparam int EDGE_FCLK = 2;   // extra FCLK cycles per phase

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_PWRUP,
        ST_TRACK,
        ST_CONV
    } seq_state_t;

    localparam logic [1:0] TM_RSVD = 2'b00;
    localparam logic [1:0] TM_POST = 2'b01;
    localparam logic [1:0] TM_PRE  = 2'b10;
    localparam logic [1:0] TM_DUAL = 2'b11;

    localparam logic [1:0] SRC_SW   = 2'b00;
    localparam logic [1:0] SRC_TMR3 = 2'b01;
    localparam logic [1:0] SRC_EXT  = 2'b10;
    localparam logic [1:0] SRC_TMR2 = 2'b11;

    function automatic logic [4:0] rpt_count(input logic [1:0] sel);
        unique case (sel)
            2'b00:   rpt_count = 5'd1;
            2'b01:   rpt_count = 5'd4;
            2'b10:   rpt_count = 5'd8;
            default: rpt_count = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/adc_seq_start.sv
module adc_seq_start
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       sw_start,
    input  logic       tmr3_ovf,
    input  logic       ext_start,
    input  logic       tmr2_ovf,
    output logic       start_req
);

    logic ext_q;

    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_start;
    end

    always_comb begin
        unique case (src_sel)
            SRC_SW:   start_req = sw_start;
            SRC_TMR3: start_req = tmr3_ovf;
            SRC_EXT:  start_req = ext_start & ~ext_q;
            default:  start_req = tmr2_ovf;
        endcase
    end

endmodule

// File: rtl/adc_seq_budget.sv
module adc_seq_budget
    import adc_seq_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int PWR_UNIT = 20
) (
    input  logic [DIV_W-1:0] sar_div,
    input  logic [TK_W-1:0]  trk_len,
    input  logic [PWR_W-1:0] pwr_time,
    output logic [CNT_W-1:0] trk_cyc,
    output logic [CNT_W-1:0] conv_cyc,
    output logic [CNT_W-1:0] pwr_cyc
);

    logic [DIV_W:0] sar_per;
    logic [PWR_W:0] pwr_units;

    assign sar_per   = {1'b0, sar_div} + {{DIV_W{1'b0}}, 1'b1};
    assign pwr_units = {1'b0, pwr_time} + {{PWR_W{1'b0}}, 1'b1};

    always_comb begin
        trk_cyc  = (CNT_W'(sar_per) << (int'(trk_len) + 1)) + CNT_W'(EDGE_FCLK);
        conv_cyc = CNT_W'(sar_per) * CNT_W'(CONV_SAR) + CNT_W'(EDGE_FCLK);
        pwr_cyc  = CNT_W'(pwr_units) * CNT_W'(PWR_UNIT);
    end

endmodule

// File: rtl/adc_seq_accum.sv
module adc_seq_accum #(
    parameter int SAMPLE_W = 12,
    parameter int RES_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                take,
    input  logic                last,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic [RES_W-1:0]    result
);

    logic [RES_W-1:0] acc;
    logic [RES_W-1:0] acc_sum;

    assign acc_sum = acc + RES_W'(sample_in);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            result <= '0;
        end else if (clear) begin
            acc <= '0;
        end else if (take) begin
            if (last) begin
                result <= acc_sum;
                acc    <= '0;
            end else begin
                acc <= acc_sum;
            end
        end
    end

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int PWR_UNIT = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  burst_en,
    input  logic [1:0]            src_sel,
    input  logic [1:0]            trk_mode,
    input  logic [TK_W-1:0]       trk_len,
    input  logic [DIV_W-1:0]      sar_div,
    input  logic [PWR_W-1:0]      pwr_time,
    input  logic [1:0]            rpt_sel,
    input  logic                  sw_start,
    input  logic                  tmr3_ovf,
    input  logic                  ext_start,
    input  logic                  tmr2_ovf,
    input  logic                  done_clr,
    input  logic [SAMPLE_W-1:0]   sample_in,
    output logic                  pwr_on,
    output logic                  track_en,
    output logic                  busy,
    output logic                  sample_take,
    output logic                  done_flag,
    output logic [SAMPLE_W+3:0]   result
);

    localparam int RES_W    = SAMPLE_W + 4;
    localparam int MAX_PER  = 1 << DIV_W;
    localparam int MAX_TRK  = MAX_PER * (1 << (1 << TK_W)) + EDGE_FCLK;
    localparam int MAX_CONV = MAX_PER * CONV_SAR + EDGE_FCLK;
    localparam int MAX_PWR  = (1 << PWR_W) * PWR_UNIT;
    localparam int MAX_TC   = (MAX_TRK > MAX_CONV) ? MAX_TRK : MAX_CONV;
    localparam int MAX_ALL  = (MAX_TC > MAX_PWR) ? MAX_TC : MAX_PWR;
    localparam int CNT_W    = $clog2(MAX_ALL + 1);

    seq_state_t       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [4:0]       conv_cnt, conv_cnt_n;
    logic [CNT_W-1:0] trk_cyc, conv_cyc, pwr_cyc;
    logic [1:0]       mode_eff;
    logic             start_req, run_ok, last_conv, phase_end, series_end;

    adc_seq_start u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_sel   (src_sel),
        .sw_start  (sw_start),
        .tmr3_ovf  (tmr3_ovf),
        .ext_start (ext_start),
        .tmr2_ovf  (tmr2_ovf),
        .start_req (start_req)
    );

    adc_seq_budget #(.CNT_W(CNT_W), .PWR_UNIT(PWR_UNIT)) u_budget (
        .sar_div  (sar_div),
        .trk_len  (trk_len),
        .pwr_time (pwr_time),
        .trk_cyc  (trk_cyc),
        .conv_cyc (conv_cyc),
        .pwr_cyc  (pwr_cyc)
    );

    // Effective tracking policy: reserved code and burst tracking-first fold to dual.
    always_comb begin
        mode_eff = trk_mode;
        if (trk_mode == TM_RSVD)             mode_eff = TM_DUAL;
        else if (burst_en && trk_mode == TM_PRE) mode_eff = TM_DUAL;
    end

    assign run_ok     = enable | burst_en;
    assign phase_end  = (cnt == '0);
    assign last_conv  = ((conv_cnt + 5'd1) >= rpt_count(rpt_sel));
    assign series_end = run_ok && (state == ST_CONV) && phase_end && last_conv;

    // Next-state logic
    always_comb begin
        state_n    = state;
        cnt_n      = phase_end ? cnt : cnt - CNT_W'(1);
        conv_cnt_n = conv_cnt;
        if (!run_ok) begin
            state_n    = ST_OFF;
            cnt_n      = '0;
            conv_cnt_n = '0;
        end else begin
            unique case (state)
                ST_OFF: state_n = ST_IDLE;
                ST_IDLE: begin
                    if (start_req) begin
                        if (mode_eff == TM_PRE) begin
                            state_n = ST_CONV;
                            cnt_n   = conv_cyc - CNT_W'(1);
                        end else if (burst_en && !enable) begin
                            state_n = ST_PWRUP;
                            cnt_n   = pwr_cyc - CNT_W'(1);
                        end else begin
                            state_n = ST_TRACK;
                            cnt_n   = trk_cyc - CNT_W'(1);
                        end
                    end
                end
                ST_PWRUP: begin
                    if (phase_end) begin
                        state_n = ST_TRACK;
                        cnt_n   = trk_cyc - CNT_W'(1);
                    end
                end
                ST_TRACK: begin
                    if (phase_end) begin
                        state_n = ST_CONV;
                        cnt_n   = conv_cyc - CNT_W'(1);
                    end
                end
                ST_CONV: begin
                    if (phase_end) begin
                        if (last_conv) begin
                            state_n    = ST_IDLE;
                            conv_cnt_n = '0;
                        end else begin
                            conv_cnt_n = conv_cnt + 5'd1;
                            if (burst_en) begin
                                state_n = ST_TRACK;
                                cnt_n   = trk_cyc - CNT_W'(1);
                            end else begin
                                state_n = ST_IDLE;
                            end
                        end
                    end
                end
                default: state_n = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_OFF;
            cnt       <= '0;
            conv_cnt  <= '0;
            done_flag <= 1'b0;
        end else begin
            state    <= state_n;
            cnt      <= cnt_n;
            conv_cnt <= conv_cnt_n;
            if (series_end)    done_flag <= 1'b1;
            else if (done_clr) done_flag <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        busy        = (state == ST_CONV);
        sample_take = run_ok && (state == ST_CONV) && phase_end;
        track_en    = (state == ST_TRACK) ||
                      ((state == ST_IDLE) && enable && (mode_eff != TM_POST));
        pwr_on      = (state == ST_PWRUP) || (state == ST_TRACK) ||
                      (state == ST_CONV)  || ((state == ST_IDLE) && enable);
    end

    adc_seq_accum #(.SAMPLE_W(SAMPLE_W), .RES_W(RES_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!run_ok),
        .take      (sample_take),
        .last      (last_conv),
        .sample_in (sample_in),
        .result    (result)
    );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int RES_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             track_en,
    input logic             pwr_on,
    input logic             sample_take,
    input logic             done_flag,
    input logic [RES_W-1:0] result
);

    // R4
    take_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_take |=> !busy);

    // R4
    busy_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    // R8
    done_on_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $fell(busy));

    // R13
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $past(sample_take));

    // R12
    unpowered_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> (!busy && !track_en));

    // R3
    track_conv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !track_en);

endmodule

bind adc_seq_top adc_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .track_en    (track_en),
    .pwr_on      (pwr_on),
    .sample_take (sample_take),
    .done_flag   (done_flag),
    .result      (result)
);

// File: tb/adc_seq_top_tb_top.sv
module adc_seq_top_tb_top;

    localparam int PU = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable, burst_en;
    logic [1:0]  src_sel, trk_mode, trk_len, rpt_sel;
    logic [4:0]  sar_div;
    logic [3:0]  pwr_time;
    logic        sw_start, tmr3_ovf, ext_start, tmr2_ovf, done_clr;
    logic [11:0] sample_in;
    logic        pwr_on, track_en, busy, sample_take, done_flag;
    logic [15:0] result;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    adc_seq_top #(.SAMPLE_W(12), .PWR_UNIT(PU)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .burst_en(burst_en),
        .src_sel(src_sel), .trk_mode(trk_mode), .trk_len(trk_len),
        .sar_div(sar_div), .pwr_time(pwr_time), .rpt_sel(rpt_sel),
        .sw_start(sw_start), .tmr3_ovf(tmr3_ovf), .ext_start(ext_start),
        .tmr2_ovf(tmr2_ovf), .done_clr(done_clr), .sample_in(sample_in),
        .pwr_on(pwr_on), .track_en(track_en), .busy(busy),
        .sample_take(sample_take), .done_flag(done_flag), .result(result)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_trk(input int div, input int tk);
        return (div + 1) * (2 << tk) + 2;
    endfunction
    function automatic int exp_conv(input int div);
        return 13 * (div + 1) + 2;
    endfunction
    function automatic int exp_pwr(input int p);
        return (p + 1) * PU;
    endfunction
    function automatic int eff_mode(input int mode, input int burst);
        if (mode == 0) return 3;
        if (burst != 0 && mode == 2) return 3;
        return mode;
    endfunction
    function automatic int rpt_len(input int sel);
        return (sel == 0) ? 1 : (2 << sel);
    endfunction

    task automatic fire(input int s);
        @(negedge clk);
        case (s)
            0: sw_start  = 1'b1;
            1: tmr3_ovf  = 1'b1;
            2: ext_start = 1'b1;
            default: tmr2_ovf = 1'b1;
        endcase
        @(negedge clk);
        sw_start = 1'b0; tmr3_ovf = 1'b0; ext_start = 1'b0; tmr2_ovf = 1'b0;
    endtask

    task automatic measure(output int np, output int nt, output int nc, output int cap);
        np = 0; nt = 0; nc = 0; cap = 0;
        for (int g = 0; g < 3000; g++) begin
            if (busy) begin
                nc++;
                sample_in = 12'($urandom);
                cap = int'(sample_in);
            end else if (nc > 0) begin
                break;
            end else if (track_en) begin
                nt++;
            end else if (pwr_on) begin
                np++;
            end
            @(negedge clk);
        end
    endtask

    task automatic configure(input int src, input int mode, input int tk, input int div,
                             input int rpt, input int burst, input int en, input int p);
        @(negedge clk);
        src_sel = 2'(src); trk_mode = 2'(mode); trk_len = 2'(tk); sar_div = 5'(div);
        rpt_sel = 2'(rpt); burst_en = burst[0]; enable = en[0]; pwr_time = 4'(p);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_series(input int src, input int mode, input int tk, input int div,
                              input int rpt, input int burst, input int en, input int p);
        int n, em, sum, np, nt, nc, cap;
        string trq;
        configure(src, mode, tk, div, rpt, burst, en, p);
        n   = rpt_len(rpt);
        em  = eff_mode(mode, burst);
        sum = 0;
        trq = (burst != 0) ? "R10" : ((em == 2) ? "R5" : "R3");
        for (int k = 0; k < n; k++) begin
            if (burst == 0 || k == 0) fire(src);
            measure(np, nt, nc, cap);
            chk("R11 power-up cycles", np, (burst != 0 && en == 0 && k == 0) ? exp_pwr(p) : 0);
            chk({trq, " track cycles"}, nt, (em == 2) ? 0 : exp_trk(div, tk));
            chk("R4 busy cycles", nc, exp_conv(div));
            sum += cap;
            if (k < n - 1) chk("R7 done early", int'(done_flag), 0);
        end
        chk("R8 done at busy fall", int'(done_flag), 1);
        chk("R7 summed result", int'(result), sum & 16'hFFFF);
        chk("R6 idle tracking", int'(track_en), (en != 0 && em != 1) ? 1 : 0);
        chk("R11 idle power", int'(pwr_on), en);
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
        chk("R8 done cleared", int'(done_flag), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int np, nt, nc, cap, rises;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; enable = 1'b0; burst_en = 1'b0; src_sel = 2'b00; trk_mode = 2'b11;
        trk_len = 2'b00; sar_div = 5'd0; pwr_time = 4'd0; rpt_sel = 2'b00;
        sw_start = 1'b0; tmr3_ovf = 1'b0; ext_start = 1'b0; tmr2_ovf = 1'b0;
        done_clr = 1'b0; sample_in = 12'd0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done_flag), 0);
        chk("R1 track_en", int'(track_en), 0);
        chk("R1 pwr_on", int'(pwr_on), 0);
        chk("R1 result", int'(result), 0);
        rst_n = 1'b1;

        // R12 powered down: starts ignored
        @(negedge clk); fire(0);
        chk("R12 off busy", int'(busy), 0);
        chk("R12 off power", int'(pwr_on), 0);

        // R2 unselected sources ignored (after-start mode, idle not tracking)
        configure(0, 1, 0, 0, 0, 0, 1, 0);
        fire(1); fire(2); fire(3);
        @(negedge clk);
        chk("R2 unselected busy", int'(busy), 0);
        chk("R2 unselected track", int'(track_en), 0);

        // R2 every source in turn
        for (int s = 0; s < 4; s++) run_series(s, 3, 0, 1, 0, 0, 1, 0);

        // R2 external level held high starts once
        configure(2, 1, 0, 0, 0, 0, 1, 0);
        ext_start = 1'b1;
        @(negedge clk);
        measure(np, nt, nc, cap);
        chk("R2 held ext conversion", nc, exp_conv(0));
        rises = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (busy || track_en) rises++;
        end
        chk("R2 held ext single start", rises, 0);
        ext_start = 1'b0;

        // R9 start during tracking ignored
        configure(0, 3, 1, 1, 0, 0, 1, 0);
        fire(0);
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
        measure(np, nt, nc, cap);
        chk("R9 track after extra start", nt, exp_trk(1, 1) - 2);
        chk("R9 conversion length", nc, exp_conv(1));
        rises = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (busy) rises++;
        end
        chk("R9 no extra conversion", rises, 0);
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;

        // R12 abort mid-series discards partial sum
        configure(0, 3, 0, 0, 1, 0, 1, 0);
        fire(0); measure(np, nt, nc, cap);
        fire(0); measure(np, nt, nc, cap);
        @(negedge clk); enable = 1'b0;
        @(negedge clk);
        chk("R12 abort power", int'(pwr_on), 0);
        chk("R12 abort done", int'(done_flag), 0);
        run_series(0, 3, 0, 0, 1, 0, 1, 0);

        // Directed corners: widest budgets, tracking-first, burst folds, power-up
        run_series(0, 3, 3, 31, 0, 0, 1, 0);
        run_series(1, 2, 2, 2, 2, 0, 1, 0);
        run_series(0, 0, 1, 1, 0, 0, 1, 0);
        run_series(3, 2, 1, 1, 1, 1, 0, 15);
        run_series(0, 1, 0, 0, 3, 1, 1, 0);
        run_series(2, 0, 2, 0, 1, 1, 0, 0);

        // Constrained random series
        for (int t = 0; t < 25; t++) begin
            int b, e;
            b = int'($urandom_range(0, 1));
            e = (b == 0) ? 1 : int'($urandom_range(0, 1));
            run_series(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                       int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                       int'($urandom_range(0, 3)), b, e, int'($urandom_range(0, 15)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule